// File: doc/BRIEF.md
# Boot-Overlay Memory Address Decoder

This block sits between a CPU with a 24-bit address bus (word-addressed, so only address bits 23 down to 1 are driven) and the memories of a small board. It decodes the lowest 128 KB of the address space into 16 KB blocks and produces active-low chip selects for two RAM banks and two ROM banks, plus one active-low select for the peripheral group. Every chip select is qualified by the CPU's active-low address strobe.

The block also raises an active-low boot-vector flag whenever the address lies in the first eight bytes of memory. During such an access the RAM bank that normally holds that range is not selected. The first ROM bank is selected in its place. The exception table that lives in RAM is therefore replaced by the boot vectors stored in ROM, which lets the CPU fetch its initial stack pointer and program counter from non-volatile storage. The logic is purely combinational and has no clock or reset.

Top module: `boardDecoder`

## Requirements
- R1: When any of address bits 23 to 17 (`addr[23:17]`) is one, every chip select (`ramSel_n`, `romSel_n`, `periphSel_n`) is high.
- R2: With the strobe low and bits 23 to 17 zero, bits 16 to 14 equal to 0 select RAM bank 1 (`ramSel_n[0]` low), except in the boot-vector range. Value 1 selects RAM bank 2 (`ramSel_n[1]` low).
- R3: With the strobe low and bits 23 to 17 zero, bits 16 to 14 equal to 2 select ROM bank 1 (`romSel_n[0]` low). Value 3 selects ROM bank 2 (`romSel_n[1]` low).
- R4: With the strobe low and bits 23 to 17 zero, bits 16 to 14 equal to 4 pull `periphSel_n` low.
- R5: With bits 23 to 17 zero, bits 16 to 14 equal to 5, 6 or 7 leave every chip select high.
- R6: `vectorFlag_n` is low exactly when address bits 23 to 3 are all zero (byte addresses 0x000000 to 0x000007). Its value does not depend on the strobe.
- R7: With the strobe low, each of the four word addresses 0x0, 0x2, 0x4 and 0x6 selects ROM bank 1 and keeps RAM bank 1 high. Byte address 0x8 selects RAM bank 1 again.
- R8: While the strobe `as_n` is high, every chip select is high.
- R9: At no address and strobe value are two or more of the five chip selects low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 23 | CPU address bits 23..1; `addr[n]` carries address bit n |
| as_n | input | 1 | Active-low address strobe |
| ramSel_n | output | 2 | Active-low RAM bank selects; bit 0 is bank 1 |
| romSel_n | output | 2 | Active-low ROM bank selects; bit 0 is bank 1 |
| periphSel_n | output | 1 | Active-low peripheral-group select |
| vectorFlag_n | output | 1 | Active-low boot-vector range flag |

## Verification
The assertions assume that `addr` and `as_n` always carry defined values and that the outputs are sampled only after the combinational logic has settled. A check made partway through an input change would see a mix of old and new select values. The bench drives the inputs only on the falling clock edge and reads the outputs a quarter period later, so every check sees settled logic. It sweeps every 16 KB block at its first word, its last word and points inside it, as well as the four vector words and the first word after them. Each upper address bit is set on its own to leave the window, and both strobe levels are applied to every address.

// File: rtl/boardDecodePkg.sv
package boardDecodePkg;
  // Address geometry (bit indices of the CPU byte address)
  localparam int ADDR_MSB   = 23;
  localparam int ADDR_LSB   = 1;
  localparam int WINDOW_LSB = 17;
  localparam int BLOCK_LSB  = 14;
  localparam int VECTOR_LSB = 3;

  localparam int BLOCK_IDX_W = WINDOW_LSB - BLOCK_LSB;
  localparam int BLOCK_COUNT = 1 << BLOCK_IDX_W;

  // Block indices inside the decode window
  localparam int BLK_RAM0   = 0;
  localparam int BLK_RAM1   = 1;
  localparam int BLK_ROM0   = 2;
  localparam int BLK_ROM1   = 3;
  localparam int BLK_PERIPH = 4;

  // Strobes from datapath to control
  typedef struct packed {
    logic                   windowHit;
    logic [BLOCK_IDX_W-1:0] blockIdx;
    logic                   vectorHit;
    logic                   cycleActive;
  } decodeStrobes_t;
endpackage

// File: rtl/decodeDatapath.sv
module decodeDatapath
  import boardDecodePkg::*;
#(
  parameter int MSB  = ADDR_MSB,
  parameter int LSB  = ADDR_LSB,
  parameter int WLSB = WINDOW_LSB,
  parameter int BLSB = BLOCK_LSB,
  parameter int VLSB = VECTOR_LSB
) (
  input  logic [MSB:LSB]  addr,
  input  logic            as_n,
  output decodeStrobes_t  strobes
);
  localparam int WINDOW_W = MSB - WLSB + 1;
  localparam int VECTOR_W = MSB - VLSB + 1;

  logic [WINDOW_W-1:0] upperBits;
  logic [VECTOR_W-1:0] vectorBits;

  assign upperBits  = addr[MSB:WLSB];
  assign vectorBits = addr[MSB:VLSB];

  always_comb begin
    strobes.windowHit   = (upperBits == '0);
    strobes.blockIdx    = addr[WLSB-1:BLSB];
    strobes.vectorHit   = (vectorBits == '0);
    strobes.cycleActive = ~as_n;
  end
endmodule

// File: rtl/decodeControl.sv
module decodeControl
  import boardDecodePkg::*;
(
  input  decodeStrobes_t strobes,
  output logic [1:0]     ramSel_n,
  output logic [1:0]     romSel_n,
  output logic           periphSel_n,
  output logic           vectorFlag_n
);
  logic [BLOCK_COUNT-1:0] blockHit;

  for (genvar blk = 0; blk < BLOCK_COUNT; blk++) begin : g_block
    assign blockHit[blk] = strobes.windowHit &&
                           (strobes.blockIdx == BLOCK_IDX_W'(blk));
  end

  logic ram0Req, ram1Req, rom0Req, rom1Req, periphReq;

  always_comb begin
    // Boot-vector overlay: steer the vector range from RAM bank 1 to ROM bank 1
    ram0Req   = blockHit[BLK_RAM0] && !strobes.vectorHit;
    ram1Req   = blockHit[BLK_RAM1];
    rom0Req   = blockHit[BLK_ROM0] || strobes.vectorHit;
    rom1Req   = blockHit[BLK_ROM1];
    periphReq = blockHit[BLK_PERIPH];

    ramSel_n     = ~({ram1Req, ram0Req} & {2{strobes.cycleActive}});
    romSel_n     = ~({rom1Req, rom0Req} & {2{strobes.cycleActive}});
    periphSel_n  = ~(periphReq && strobes.cycleActive);
    vectorFlag_n = ~strobes.vectorHit;
  end
endmodule

// File: rtl/boardDecoder.sv
module boardDecoder
  import boardDecodePkg::*;
(
  input  logic [ADDR_MSB:ADDR_LSB] addr,
  input  logic                     as_n,
  output logic [1:0]               ramSel_n,
  output logic [1:0]               romSel_n,
  output logic                     periphSel_n,
  output logic                     vectorFlag_n
);
  decodeStrobes_t strobes;

  decodeDatapath i_datapath (
    .addr    (addr),
    .as_n    (as_n),
    .strobes (strobes)
  );

  decodeControl i_control (
    .strobes      (strobes),
    .ramSel_n     (ramSel_n),
    .romSel_n     (romSel_n),
    .periphSel_n  (periphSel_n),
    .vectorFlag_n (vectorFlag_n)
  );
endmodule

// File: rtl/boardDecoderChecker.sv
module boardDecoderChecker
  import boardDecodePkg::*;
(
  input logic [ADDR_MSB:ADDR_LSB] addr,
  input logic                     as_n,
  input logic [1:0]               ramSel_n,
  input logic [1:0]               romSel_n,
  input logic                     periphSel_n,
  input logic                     vectorFlag_n
);
  logic [4:0] activeSel;
  assign activeSel = ~{periphSel_n, romSel_n, ramSel_n};

  always_comb begin
    AST_SINGLE_SELECT: assert ($countones(activeSel) <= 1) else $error("multiple selects"); // R9
    AST_STROBE_IDLE: assert (!as_n || activeSel == '0) else $error("select without strobe"); // R8
    AST_OUT_OF_WINDOW: assert (addr[ADDR_MSB:WINDOW_LSB] == '0 || activeSel == '0) else $error("select outside window"); // R1
    AST_VECTOR_OVERLAY: assert (as_n || vectorFlag_n || (!romSel_n[0] && ramSel_n[0])) else $error("overlay missing"); // R7
  end
endmodule

bind boardDecoder boardDecoderChecker i_checker (
  .addr         (addr),
  .as_n         (as_n),
  .ramSel_n     (ramSel_n),
  .romSel_n     (romSel_n),
  .periphSel_n  (periphSel_n),
  .vectorFlag_n (vectorFlag_n)
);

// File: tb/test_boardDecoder.sv
module test_boardDecoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [23:1] addr = '0;
  logic        as_n = 1'b1;
  logic [1:0]  ramSel_n, romSel_n;
  logic        periphSel_n, vectorFlag_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boardDecoder i_boardDecoder (
    .addr(addr), .as_n(as_n), .ramSel_n(ramSel_n), .romSel_n(romSel_n),
    .periphSel_n(periphSel_n), .vectorFlag_n(vectorFlag_n)
  );

  // Expected outputs from the byte address; vector {periph, rom1, rom0, ram1, ram0}, active low
  function automatic logic [4:0] expSel(input int unsigned byteAddr, input logic strobeN);
    logic [4:0] act = '0;
    if (!strobeN) begin
      if (byteAddr >= 32'h8      && byteAddr < 32'h4000)  act[0] = 1'b1;
      if (byteAddr >= 32'h4000   && byteAddr < 32'h8000)  act[1] = 1'b1;
      if (byteAddr < 32'h8 || (byteAddr >= 32'h8000 && byteAddr < 32'hC000)) act[2] = 1'b1;
      if (byteAddr >= 32'hC000   && byteAddr < 32'h10000) act[3] = 1'b1;
      if (byteAddr >= 32'h10000  && byteAddr < 32'h14000) act[4] = 1'b1;
    end
    return ~act;
  endfunction

  task automatic applyAndCheck(input int unsigned byteAddr, input logic strobeN, input string tag);
    logic [4:0] got, exp;
    logic       expFlag;
    @(negedge clk);
    addr = byteAddr[23:1];
    as_n = strobeN;
    #(CLK_PERIOD/4);
    got = {periphSel_n, romSel_n, ramSel_n};
    exp = expSel(byteAddr, strobeN);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h as_n=%0b selects actual=%b expected=%b", tag, byteAddr, strobeN, got, exp);
    end
    checks++;
    if ($countones(~got) > 1) begin
      errors++;
      $display("FAIL R9 addr=%h actual=%b expected at most one low", byteAddr, got);
    end
    expFlag = !(byteAddr < 32'h8);
    checks++;
    if (vectorFlag_n !== expFlag) begin
      errors++;
      $display("FAIL R6 addr=%h as_n=%0b flag actual=%b expected=%b", byteAddr, strobeN, vectorFlag_n, expFlag);
    end
  endtask

  initial begin
    int unsigned offs [7] = '{32'h0, 32'h2, 32'h6, 32'h8, 32'hA, 32'h2000, 32'h3FFE};
    // Idle state with strobe high
    #(CLK_PERIOD/4);
    checks++;
    if ({periphSel_n, romSel_n, ramSel_n} !== 5'b11111) begin
      errors++;
      $display("FAIL R8 idle selects actual=%b expected=11111", {periphSel_n, romSel_n, ramSel_n});
    end
    for (int blk = 0; blk < 8; blk++) begin
      for (int o = 0; o < 7; o++) begin
        for (int hb = 16; hb <= 23; hb++) begin
          for (int s = 0; s < 2; s++) begin
            int unsigned a = (blk * 32'h4000) + offs[o];
            string tag;
            if (hb > 16) a = a | (32'h1 << hb);
            if (hb > 16) tag = "R1";
            else if (s == 1) tag = "R8";
            else if (a < 32'h10) tag = "R7";
            else if (blk < 2) tag = "R2";
            else if (blk < 4) tag = "R3";
            else if (blk == 4) tag = "R4";
            else tag = "R5";
            applyAndCheck(a, s[0], tag);
          end
        end
      end
    end
    // All four vector words plus neighbours, both strobe levels
    for (int w = 0; w < 6; w++) begin
      applyAndCheck(w * 2, 1'b0, "R7");
      applyAndCheck(w * 2, 1'b1, "R6");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule